// File: doc/BRIEF.md
# Sequencing ADC Conversion Controller

This block is the host-side sequencer for a 16-input multiplexed analog-to-digital converter. Software reaches it through a small register window on an 8/16-bit bus. It picks the input channel and waits out a settling interval whenever the channel changes. It then fires a one-cycle start pulse at the converter, captures the converter's result and raises a done flag, which can drive an interrupt line.

Software can trigger each conversion by hand. It can also have the next conversion start by itself when the upper result byte is read. With auto-advance on, the channel steps forward after every conversion and wraps inside a programmable scan window of 2, 4, 8 or 16 inputs. A trigger that arrives while a conversion or a settling interval is running is kept and carried out afterwards.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the status byte (read at offset 0) is 0x10, `irq` is low, `chanSel` is 0 and `convStart` is low.
- R2: A write of any data to offset 2 produces exactly one single-cycle `convStart` pulse once the block is idle and settled.
- R3: With control bit 3 set, reading the result high byte starts a new conversion with no convert write; with bit 3 clear it does not.
- R4: A write to offset 1 loads bits 3:0 into `chanSel`. With control bit 4 set, the channel advances by one when a conversion completes; otherwise it stays fixed.
- R5: Each channel change (select write or auto-advance) clears status bit 4 for SETTLE_SHORT cycles (`settleLong` low) or SETTLE_LONG cycles (`settleLong` high). No conversion starts in that window.
- R6: Status bit 7 (done) sets when a result is captured. It clears on a read of the high byte (offset 4 or 5) or on any write to offset 9.
- R7: `irq` is high exactly while done is set and control bit 0 is set.
- R8: A 16-bit write at offset 1 loads the channel from the low byte and also acts as a convert write, so one bus cycle selects the channel and triggers the conversion.
- R9: The result is sign-extended to 16 bits. Offset 3 reads the low byte, and offset 4 or 5 (narrow) reads the high byte. A 16-bit read at offset 4 returns the whole word. A 12-bit code 0x7FF reads 0x07FF and 0x800 reads 0xF800.
- R10: Control bits 6:5 set the scan window: 00 gives 16 channels, 01 gives 8, 10 gives 4 and 11 gives 2. An auto-advanced channel that reaches the window size wraps to 0.
- R11: A convert request that arrives during a conversion or a settling interval is held and started when that phase ends. It is never dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register offset |
| busWrEn | input | 1 | Write strobe, one cycle per access |
| busRdEn | input | 1 | Read strobe, one cycle per access |
| busWide | input | 1 | High: 16-bit access; low: 8-bit access on the low lane |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data, combinational, zero when no read is active |
| settleLong | input | 1 | Selects the long settling interval |
| convStart | output | 1 | One-cycle start pulse to the converter |
| convDone | input | 1 | One-cycle pulse from the converter with valid `convData` |
| convData | input | RES_BITS | Two's-complement conversion result |
| chanSel | output | CH_BITS | Multiplexer channel |
| irq | output | 1 | Interrupt request |

## Verification
A settling counter that sticks shows up in two ways: status bit 4 never returns to 1, and `convStart` never follows a convert write. Both are visible within SETTLE_LONG plus a few cycles. A done flag that clears at the wrong time shows on `irq` and in status bit 7 on the very next read. A lost pending trigger shows as a missing start pulse one converter latency later. A bad wrap in the channel stepper appears on `chanSel` in the cycle after the converter's done pulse. Result sign handling is checked byte by byte and through a full-word read.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam logic [3:0] OFS_CTRL    = 4'h0;
  localparam logic [3:0] OFS_SEL     = 4'h1;
  localparam logic [3:0] OFS_CONV    = 4'h2;
  localparam logic [3:0] OFS_RLO     = 4'h3;
  localparam logic [3:0] OFS_RHI     = 4'h4;
  localparam logic [3:0] OFS_RHI_ALT = 4'h5;
  localparam logic [3:0] OFS_CLR     = 4'h9;

  // decoded bus accesses, one cycle each
  typedef struct packed {
    logic ctrlWr;
    logic selWr;
    logic convWr;
    logic hiRd;
    logic clrWr;
  } busStb_t;

  // sequencer strobes into the datapath
  typedef struct packed {
    logic captureRes;
    logic loadSettle;
    logic advanceChan;
  } seqStb_t;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_CONV = 1'b1} seqState_t;
endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  busStb_t busStb,
  input  logic    autoTrig,
  input  logic    autoInc,
  input  logic    settled,
  input  logic    convDone,
  output seqStb_t seqStb,
  output logic    convStart,
  output logic    busy
);
  seqState_t state;
  logic pending;
  logic trigger;
  logic launch;
  logic unusedStb;

  assign unusedStb = busStb.ctrlWr ^ busStb.clrWr;

  always_comb begin
    trigger            = busStb.convWr | (busStb.hiRd & autoTrig);
    // a select write in the same cycle restarts settling, so hold off
    launch             = (state == SEQ_IDLE) & pending & settled & ~busStb.selWr;
    seqStb.captureRes  = (state == SEQ_CONV) & convDone;
    seqStb.advanceChan = seqStb.captureRes & autoInc;
    seqStb.loadSettle  = busStb.selWr | seqStb.advanceChan;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      pending   <= 1'b0;
      convStart <= 1'b0;
    end else begin
      convStart <= launch;
      if (launch) begin
        state   <= SEQ_CONV;
        pending <= trigger;
      end else begin
        pending <= pending | trigger;
        if (seqStb.captureRes) state <= SEQ_IDLE;
      end
    end
  end

  assign busy = (state == SEQ_CONV) | pending;
endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter  int NUM_CH       = 16,
  parameter  int RES_BITS     = 12,
  parameter  int SETTLE_SHORT = 6,
  parameter  int SETTLE_LONG  = 12,
  localparam int CH_BITS      = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  busStb_t             busStb,
  input  logic                busRdEn,
  input  logic                busWide,
  input  logic [3:0]          busAddr,
  input  logic [15:0]         busWrData,
  input  seqStb_t             seqStb,
  input  logic [RES_BITS-1:0] convData,
  input  logic                settleLong,
  input  logic                busy,
  output logic [15:0]         rdData,
  output logic [CH_BITS-1:0]  chanSel,
  output logic                irq,
  output logic                autoTrig,
  output logic                autoInc,
  output logic                settled,
  output logic                doneFlag
);
  localparam int CNT_W = CH_BITS + 1;
  localparam int SET_W = $clog2(SETTLE_LONG + 1);

  logic [1:0]         scanLim;
  logic               irqEn;
  logic [SET_W-1:0]   settleCnt;
  logic [15:0]        resReg;
  logic [15:0]        resExt;
  logic [CNT_W-1:0]   scanCount;
  logic [CNT_W-1:0]   chanInc;
  logic [CH_BITS-1:0] chanNext;
  logic [7:0]         statusByte;
  logic               unusedBits;

  // convert data and spare control bits carry no meaning
  assign unusedBits = ^{busWrData[15:8], busWrData[7], busWrData[2:1], busStb.convWr};

  generate
    if (RES_BITS < 16) begin : g_signExt
      assign resExt = {{(16-RES_BITS){convData[RES_BITS-1]}}, convData};
    end else begin : g_full
      assign resExt = convData[15:0];
    end
  endgenerate

  always_comb begin
    scanCount = CNT_W'(NUM_CH) >> scanLim;
    chanInc   = CNT_W'(chanSel) + CNT_W'(1);
    chanNext  = (chanInc >= scanCount) ? '0 : chanInc[CH_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanLim  <= 2'b00;
      autoInc  <= 1'b0;
      autoTrig <= 1'b0;
      irqEn    <= 1'b0;
    end else if (busStb.ctrlWr) begin
      scanLim  <= busWrData[6:5];
      autoInc  <= busWrData[4];
      autoTrig <= busWrData[3];
      irqEn    <= busWrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   chanSel <= '0;
    else if (busStb.selWr)       chanSel <= busWrData[CH_BITS-1:0];
    else if (seqStb.advanceChan) chanSel <= chanNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  settleCnt <= '0;
    else if (seqStb.loadSettle) settleCnt <= settleLong ? SET_W'(SETTLE_LONG) : SET_W'(SETTLE_SHORT);
    else if (settleCnt != '0)   settleCnt <= settleCnt - SET_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resReg   <= '0;
      doneFlag <= 1'b0;
    end else begin
      if (seqStb.captureRes) resReg <= resExt;
      if (seqStb.captureRes)                 doneFlag <= 1'b1;
      else if (busStb.hiRd | busStb.clrWr)   doneFlag <= 1'b0;
    end
  end

  assign settled    = (settleCnt == '0);
  assign irq        = doneFlag & irqEn;
  assign statusByte = {doneFlag, busy, 1'b0, settled, 4'b0000};

  always_comb begin
    rdData = '0;
    if (busRdEn) begin
      case (busAddr)
        OFS_CTRL:    rdData = {8'h00, statusByte};
        OFS_RLO:     rdData = {8'h00, resReg[7:0]};
        OFS_RHI:     rdData = busWide ? resReg : {8'h00, resReg[15:8]};
        OFS_RHI_ALT: rdData = {8'h00, resReg[15:8]};
        default:     rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter  int NUM_CH       = 16,
  parameter  int RES_BITS     = 12,
  parameter  int SETTLE_SHORT = 6,
  parameter  int SETTLE_LONG  = 12,
  localparam int CH_BITS      = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [3:0]          busAddr,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic                busWide,
  input  logic [15:0]         busWrData,
  output logic [15:0]         busRdData,
  input  logic                settleLong,
  output logic                convStart,
  input  logic                convDone,
  input  logic [RES_BITS-1:0] convData,
  output logic [CH_BITS-1:0]  chanSel,
  output logic                irq
);
  busStb_t busStb;
  seqStb_t seqStb;
  logic autoTrig, autoInc, settled, doneFlag, busy;

  always_comb begin
    busStb.ctrlWr = busWrEn & (busAddr == OFS_CTRL);
    busStb.selWr  = busWrEn & (busAddr == OFS_SEL);
    busStb.convWr = busWrEn & ((busAddr == OFS_CONV) | (busWide & (busAddr == OFS_SEL)));
    busStb.hiRd   = busRdEn & ((busAddr == OFS_RHI) | (busAddr == OFS_RHI_ALT));
    busStb.clrWr  = busWrEn & (busAddr == OFS_CLR);
  end

  adc_seq_fsm uFsm (
    .clk(clk), .rstN(rstN), .busStb(busStb), .autoTrig(autoTrig), .autoInc(autoInc),
    .settled(settled), .convDone(convDone), .seqStb(seqStb), .convStart(convStart), .busy(busy)
  );

  adc_seq_dp #(
    .NUM_CH(NUM_CH), .RES_BITS(RES_BITS), .SETTLE_SHORT(SETTLE_SHORT), .SETTLE_LONG(SETTLE_LONG)
  ) uDp (
    .clk(clk), .rstN(rstN), .busStb(busStb), .busRdEn(busRdEn), .busWide(busWide),
    .busAddr(busAddr), .busWrData(busWrData), .seqStb(seqStb), .convData(convData),
    .settleLong(settleLong), .busy(busy), .rdData(busRdData), .chanSel(chanSel), .irq(irq),
    .autoTrig(autoTrig), .autoInc(autoInc), .settled(settled), .doneFlag(doneFlag)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CH_BITS = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWrEn,
  input logic [3:0]         busAddr,
  input logic               convStart,
  input logic               convDone,
  input logic               irq,
  input logic [CH_BITS-1:0] chanSel,
  input logic               doneFlag,
  input logic               settled
);
  p_irq_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> doneFlag);

  p_start_settled_r5: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> settled);

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  p_done_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(convDone));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 4'h9 && !convDone) |=> !doneFlag);

  p_chan_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!(busWrEn && busAddr == 4'h1) && !convDone) |=> $stable(chanSel));
endmodule

bind adc_seq_ctrl adc_seq_chk #(.CH_BITS(CH_BITS)) uChk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .convStart(convStart),
  .convDone(convDone), .irq(irq), .chanSel(chanSel), .doneFlag(doneFlag), .settled(settled)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 16;
  localparam int RES_BITS   = 12;
  localparam int SHORT      = 6;
  localparam int LONG       = 12;
  localparam int LAT        = 4;
  localparam int DONE_WAIT  = LONG + LAT + 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] busAddr = 4'h0;
  logic busWrEn = 1'b0, busRdEn = 1'b0, busWide = 1'b0;
  logic [15:0] busWrData = 16'h0;
  logic [15:0] busRdData;
  logic settleLong = 1'b0;
  logic convStart;
  logic convDone = 1'b0;
  logic [RES_BITS-1:0] convData = '0;
  logic [3:0] chanSel;
  logic irq;

  int checks = 0, fails = 0, startCount = 0;
  logic [3:0] lastStartChan = 4'h0;
  logic [RES_BITS-1:0] modelData = '0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS), .SETTLE_SHORT(SHORT), .SETTLE_LONG(LONG)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWide(busWide), .busWrData(busWrData), .busRdData(busRdData), .settleLong(settleLong),
    .convStart(convStart), .convDone(convDone), .convData(convData), .chanSel(chanSel), .irq(irq)
  );

  // converter model: fixed latency, one-cycle done pulse
  initial begin
    forever begin
      @(posedge clk);
      if (convStart === 1'b1) begin
        startCount++;
        lastStartChan = chanSel;
        repeat (LAT) @(posedge clk);
        #1;
        convData = modelData;
        convDone = 1'b1;
        @(posedge clk);
        #1;
        convDone = 1'b0;
      end
    end
  end

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [15:0] d, input logic wide);
    @(negedge clk);
    busAddr = a; busWrData = d; busWide = wide; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWide = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, input logic wide, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWide = wide; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0; busWide = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // call right after the select write returns: samples status bit 4 each cycle
  task automatic checkSettle(input int n);
    busAddr = 4'h0; busRdEn = 1'b1;
    #1 chkEq("R5 settle bit sample 0", {31'd0, busRdData[4]}, 32'd0);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      #1 chkEq($sformatf("R5 settle bit sample %0d", i), {31'd0, busRdData[4]}, (i >= n) ? 32'd1 : 32'd0);
    end
    busRdEn = 1'b0;
  endtask

  task automatic tReset();
    logic [15:0] d;
    chkEq("R1 convStart", {31'd0, convStart}, 32'd0);
    chkEq("R1 irq", {31'd0, irq}, 32'd0);
    chkEq("R1 chanSel", {28'd0, chanSel}, 32'd0);
    busRead(4'h0, 1'b0, d);
    chkEq("R1 status", {16'd0, d}, 32'h10);
  endtask

  task automatic tManual();
    logic [15:0] d;
    int s0;
    busWrite(4'h0, 16'h0001, 1'b0);
    modelData = 12'h7FF;
    s0 = startCount;
    busWrite(4'h2, 16'h005A, 1'b0);
    waitCyc(DONE_WAIT);
    chkEq("R2 one start per convert write", startCount, s0 + 1);
    busRead(4'h0, 1'b0, d);
    chkEq("R6 done set", {31'd0, d[7]}, 32'd1);
    chkEq("R7 irq with done and enable", {31'd0, irq}, 32'd1);
    busRead(4'h3, 1'b0, d);
    chkEq("R9 low byte", {16'd0, d}, 32'hFF);
    busRead(4'h0, 1'b0, d);
    chkEq("R6 low read keeps done", {31'd0, d[7]}, 32'd1);
    busRead(4'h4, 1'b0, d);
    chkEq("R9 high byte positive", {16'd0, d}, 32'h07);
    busRead(4'h0, 1'b0, d);
    chkEq("R6 high read clears done", {31'd0, d[7]}, 32'd0);
    chkEq("R7 irq drops with done", {31'd0, irq}, 32'd0);
  endtask

  task automatic tNegWide();
    logic [15:0] d;
    modelData = 12'h800;
    busWrite(4'h2, 16'hFFFF, 1'b0);
    waitCyc(DONE_WAIT);
    busRead(4'h5, 1'b0, d);
    chkEq("R9 high byte at alternate offset", {16'd0, d}, 32'hF8);
    modelData = 12'h800;
    busWrite(4'h2, 16'h0000, 1'b0);
    waitCyc(DONE_WAIT);
    busRead(4'h4, 1'b1, d);
    chkEq("R9 wide result sign extended", {16'd0, d}, 32'hF800);
    busRead(4'h0, 1'b0, d);
    chkEq("R6 wide high read clears done", {31'd0, d[7]}, 32'd0);
  endtask

  task automatic tSettle();
    int s0;
    busWrite(4'h1, 16'h0005, 1'b0);
    chkEq("R4 select loads channel", {28'd0, chanSel}, 32'd5);
    checkSettle(SHORT);
    s0 = startCount;
    busWrite(4'h1, 16'h0007, 1'b0);
    busWrite(4'h2, 16'h0000, 1'b0);
    chkEq("R11 held during settle", startCount, s0);
    waitCyc(3);
    chkEq("R5 no start while settling", startCount, s0);
    waitCyc(DONE_WAIT);
    chkEq("R11 held request started", startCount, s0 + 1);
    chkEq("R4 conversion on selected channel", {28'd0, lastStartChan}, 32'd7);
  endtask

  task automatic tLong();
    @(negedge clk);
    settleLong = 1'b1;
    busWrite(4'h1, 16'h0004, 1'b0);
    checkSettle(LONG);
    settleLong = 1'b0;
  endtask

  task automatic tWide();
    int s0;
    s0 = startCount;
    busWrite(4'h1, 16'hAB03, 1'b1);
    chkEq("R8 wide select loads channel", {28'd0, chanSel}, 32'd3);
    waitCyc(DONE_WAIT);
    chkEq("R8 wide select triggers", startCount, s0 + 1);
    chkEq("R8 started on new channel", {28'd0, lastStartChan}, 32'd3);
  endtask

  task automatic tScan();
    busWrite(4'h0, 16'h0050, 1'b0);
    busWrite(4'h1, 16'h0002, 1'b0);
    busWrite(4'h2, 16'h0000, 1'b0);
    waitCyc(DONE_WAIT);
    chkEq("R4 channel advances", {28'd0, chanSel}, 32'd3);
    chkEq("R4 start on old channel", {28'd0, lastStartChan}, 32'd2);
    busWrite(4'h2, 16'h0000, 1'b0);
    waitCyc(DONE_WAIT);
    chkEq("R10 wrap at four", {28'd0, chanSel}, 32'd0);
    chkEq("R10 last before wrap", {28'd0, lastStartChan}, 32'd3);
    busWrite(4'h0, 16'h0070, 1'b0);
    busWrite(4'h1, 16'h0001, 1'b0);
    busWrite(4'h2, 16'h0000, 1'b0);
    waitCyc(DONE_WAIT);
    chkEq("R10 wrap at two", {28'd0, chanSel}, 32'd0);
    busWrite(4'h0, 16'h0000, 1'b0);
    busWrite(4'h1, 16'h0009, 1'b0);
    busWrite(4'h2, 16'h0000, 1'b0);
    waitCyc(DONE_WAIT);
    chkEq("R4 fixed channel without advance", {28'd0, chanSel}, 32'd9);
    chkEq("R4 start channel fixed", {28'd0, lastStartChan}, 32'd9);
  endtask

  task automatic tAutoTrig();
    logic [15:0] d;
    int s0;
    busWrite(4'h0, 16'h0008, 1'b0);
    s0 = startCount;
    busWrite(4'h2, 16'h0000, 1'b0);
    waitCyc(DONE_WAIT);
    chkEq("R3 first manual start", startCount, s0 + 1);
    busRead(4'h4, 1'b0, d);
    waitCyc(DONE_WAIT);
    chkEq("R3 high read retriggers", startCount, s0 + 2);
    busRead(4'h4, 1'b0, d);
    waitCyc(DONE_WAIT);
    chkEq("R3 second retrigger", startCount, s0 + 3);
    busWrite(4'h0, 16'h0000, 1'b0);
    busRead(4'h4, 1'b0, d);
    waitCyc(DONE_WAIT);
    chkEq("R3 no retrigger when disabled", startCount, s0 + 3);
  endtask

  task automatic tHeld();
    int s0;
    s0 = startCount;
    busWrite(4'h2, 16'h0000, 1'b0);
    waitCyc(2);
    busWrite(4'h2, 16'h0000, 1'b0);
    waitCyc(2 * DONE_WAIT);
    chkEq("R11 request during conversion kept", startCount, s0 + 2);
  endtask

  task automatic tClear();
    logic [15:0] d;
    busWrite(4'h0, 16'h0001, 1'b0);
    modelData = 12'h123;
    busWrite(4'h2, 16'h0000, 1'b0);
    waitCyc(DONE_WAIT);
    chkEq("R7 irq raised", {31'd0, irq}, 32'd1);
    busWrite(4'h9, 16'h0000, 1'b0);
    busRead(4'h0, 1'b0, d);
    chkEq("R6 clear-flags write clears done", {31'd0, d[7]}, 32'd0);
    chkEq("R7 irq cleared", {31'd0, irq}, 32'd0);
    busRead(4'h3, 1'b0, d);
    chkEq("R9 result kept after clear", {16'd0, d}, 32'h23);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tManual();
    tNegWide();
    tSettle();
    tLong();
    tWide();
    tScan();
    tAutoTrig();
    tHeld();
    tClear();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule